// File: doc/BRIEF.md
# Two-Instruction Multi-Cycle Sequencer

This block is the control path of a small processor whose program store is separate from all data storage. It reads 16-bit instruction words from a read-only program memory over a registered address output and a read strobe. Each word is walked through explicit processing phases: fetch, decode, address evaluation, operand fetch, execute and store. A phase that the current instruction does not need is skipped.

Two operations are recognised. The first is a register-to-register add on a file of thirty-two 8-bit registers. The second is a PC-relative jump with a signed 12-bit offset. Every other word is retired as a no-op that only advances the program counter.

A debug port exposes the program counter. It also lets one register be read and written by index, so the file can be preloaded and inspected.

Top module: `tiny_seq_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC and all 32 registers clear to zero and `pm_rd` is low in the next cycle. After release, the first read strobe carries address 0.
- R2: A fetch drives `pm_rd` high for exactly one cycle, with `pm_addr` equal to the current PC. The word on `pm_data` in the following cycle becomes the instruction, and the PC then advances by one.
- R3: A word whose bits [15:10] are 000011 adds two registers. The destination index is bits [8:4], and the source index is bit 9 followed by bits [3:0]. The destination receives (Rd + Rr) mod 256 and no other register changes.
- R4: A word whose bits [15:12] are 1100 jumps. Bits [11:0] form a two's-complement offset k, and the new PC is (address of the jump + 1 + k) mod 4096.
- R5: Any word that is neither an add nor a jump leaves every register unchanged, and the next fetch is from the following address.
- R6: From one read strobe to the next there are 4 cycles after a no-op, 5 after a jump and 7 after an add.
- R7: `dbg_reg` always shows register `dbg_sel`, and `dbg_pc` always shows the PC.
- R8: With `dbg_we` high at a rising edge, register `dbg_sel` takes `dbg_wdata`. This write has priority over an add writeback in the same cycle.
- R9: The PC wraps modulo 4096, both on the increment after address 4095 and on jump arithmetic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pm_addr | output | 12 | Program memory address |
| pm_rd | output | 1 | Program memory read strobe |
| pm_data | input | 16 | Program memory word, valid one cycle after the strobe |
| dbg_sel | input | 5 | Register index for debug read and write |
| dbg_we | input | 1 | Debug register write enable |
| dbg_wdata | input | 8 | Debug register write data |
| dbg_reg | output | 8 | Contents of register `dbg_sel` |
| dbg_pc | output | 12 | Current program counter |

## Verification
The hardest situation to reach from the ports is the PC wrap. It needs a fetch at address 4095, and a program that wanders randomly almost never lands there. The stimulus therefore places a directed backward jump that lands two words below the top of memory. It puts a forward jump at 4095, so the wrapped increment and the jump arithmetic are exercised together. The register file also starts at all zeros, and adds alone can never leave that state. The stimulus first runs a stretch of no-ops and loads random values through the debug write port during that stretch. The random program is then checked at every fetch against an instruction-level model kept in the bench.

// File: rtl/tiny_seq_core.sv
module tiny_seq_core #(
  parameter int PC_W = 12,
  parameter int DW   = 8,
  parameter int IW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] pm_addr,
  output logic            pm_rd,
  input  logic [IW-1:0]   pm_data,
  input  logic [4:0]      dbg_sel,
  input  logic            dbg_we,
  input  logic [DW-1:0]   dbg_wdata,
  output logic [DW-1:0]   dbg_reg,
  output logic [PC_W-1:0] dbg_pc
);
  localparam int NREG = 32;

  typedef enum logic [2:0] {
    PH_FA, PH_FR, PH_FW, PH_DEC, PH_EA, PH_OP, PH_EX, PH_ST
  } phase_t;

  phase_t          state;
  logic [PC_W-1:0] pc, par;
  logic [IW-1:0]   ir;
  logic [DW-1:0]   opa, opb, res;
  logic [DW-1:0]   rf [NREG];

  logic            is_add, is_jmp;
  logic [4:0]      fd, fr;
  logic [PC_W-1:0] koff;

  assign is_add  = ir[15:10] == 6'b000011;
  assign is_jmp  = ir[15:12] == 4'b1100;
  assign fd      = ir[8:4];
  assign fr      = {ir[9], ir[3:0]};
  assign koff    = PC_W'($signed(ir[11:0]));

  assign pm_addr = par;
  assign pm_rd   = state == PH_FR;
  assign dbg_reg = rf[dbg_sel];
  assign dbg_pc  = pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PH_FA;
      pc    <= '0;
      par   <= '0;
      ir    <= '0;
      opa   <= '0;
      opb   <= '0;
      res   <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (state)
        PH_FA: begin
          par   <= pc;
          state <= PH_FR;
        end
        PH_FR: state <= PH_FW;
        PH_FW: begin
          ir    <= pm_data;
          pc    <= pc + 1'b1;
          state <= PH_DEC;
        end
        PH_DEC: begin
          if (is_add)      state <= PH_OP;
          else if (is_jmp) state <= PH_EA;
          else             state <= PH_FA;
        end
        PH_EA: begin
          pc    <= pc + koff;
          state <= PH_FA;
        end
        PH_OP: begin
          opa   <= rf[fd];
          opb   <= rf[fr];
          state <= PH_EX;
        end
        PH_EX: begin
          res   <= opa + opb;
          state <= PH_ST;
        end
        default: begin
          rf[fd] <= res;
          state  <= PH_FA;
        end
      endcase
      if (dbg_we) rf[dbg_sel] <= dbg_wdata;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc == '0 && !pm_rd));

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pm_rd |=> !pm_rd);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    pm_rd |=> ##1 (pc == $past(pm_addr, 2) + 1'b1));

  // R6
  min_gap_chk: assert property (@(posedge clk) disable iff (rst)
    pm_rd |=> !pm_rd ##1 !pm_rd ##1 !pm_rd);

  // R4
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (state == PH_EA) |=> (pc == $past(pc) + PC_W'($signed($past(ir[11:0])))));

  // R3
  add_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (state == PH_ST && !dbg_we) |=> (rf[$past(fd)] == $past(res)));

  // R8
  dbg_wr_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_we |=> (rf[$past(dbg_sel)] == $past(dbg_wdata)));
endmodule

// File: tb/tiny_seq_core_tb.sv
`timescale 1ns/1ps
module tiny_seq_core_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] pm_addr;
  logic        pm_rd;
  logic [15:0] pm_data;
  logic [4:0]  dbg_sel;
  logic        dbg_we;
  logic [7:0]  dbg_wdata;
  logic [7:0]  dbg_reg;
  logic [11:0] dbg_pc;

  always #2.5 clk = ~clk;

  tiny_seq_core u_dut (
    .clk(clk), .rst(rst), .pm_addr(pm_addr), .pm_rd(pm_rd), .pm_data(pm_data),
    .dbg_sel(dbg_sel), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
    .dbg_reg(dbg_reg), .dbg_pc(dbg_pc)
  );

  logic [15:0] mem [4096];
  logic [7:0]  mrf [32];
  logic [11:0] mpc;
  int n_chk = 0, n_fail = 0;
  int gap = 0, last_kind = 0, fetches = 0;
  bit wr_done = 0, done = 0, reported = 0;

  always @(posedge clk) if (pm_rd) pm_data <= mem[pm_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  function automatic logic [15:0] gen_word();
    logic [15:0] w;
    int r = $urandom % 10;
    if (r < 5) begin
      w = {6'b000011, 10'($urandom)};
    end else if (r < 7) begin
      w = {4'b1100, 12'($urandom)};
      if (w[11:0] == 12'hFFF) w[11:0] = 12'h010;
    end else begin
      do w = 16'($urandom);
      while (w[15:10] == 6'b000011 || w[15:12] == 4'b1100);
    end
    return w;
  endfunction

  // kind: 1 no-op, 2 jump, 3 add
  function automatic int kind_of(input logic [15:0] w);
    if (w[15:10] == 6'b000011) return 3;
    if (w[15:12] == 4'b1100) return 2;
    return 1;
  endfunction

  always @(negedge clk) begin
    if (!rst && !done) begin
      gap++;
      if (pm_rd) begin
        logic [15:0] w;
        int exp_gap;
        string rq;
        rq = (last_kind == 2) ? "R4/R9" : (last_kind == 3) ? "R3" : "R5";
        chk(pm_addr == mpc, rq, pm_addr, mpc);
        chk(dbg_pc == mpc, "R7", dbg_pc, mpc);
        if (fetches == 0) chk(pm_addr == 12'd0, "R1", pm_addr, 0);
        if (last_kind != 0) begin
          exp_gap = (last_kind == 1) ? 4 : (last_kind == 2) ? 5 : 7;
          chk(gap == exp_gap, "R6", gap, exp_gap);
        end
        if (wr_done) chk(dbg_reg == mrf[dbg_sel], "R3/R8", dbg_reg, mrf[dbg_sel]);
        if (wr_done && fetches >= 3000) begin
          for (int i = 0; i < 32; i++) begin
            dbg_sel = 5'(i);
            #0.05;
            chk(dbg_reg == mrf[i], "R3", dbg_reg, mrf[i]);
          end
          done = 1;
        end else begin
          w = mem[mpc];
          last_kind = kind_of(w);
          mpc = mpc + 12'd1;
          if (last_kind == 3)
            mrf[w[8:4]] = mrf[w[8:4]] + mrf[{w[9], w[3:0]}];
          else if (last_kind == 2)
            mpc = mpc + 12'($signed(w[11:0]));
          fetches++;
          gap = 0;
          if (wr_done) dbg_sel = 5'($urandom);
        end
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int a = 0; a < 4096; a++) mem[a] = gen_word();
    for (int a = 0; a < 16; a++) mem[a] = 16'h0000;
    mem[16]   = 16'h0C13;  // add r1,r3
    mem[17]   = 16'h0C88;  // add r8,r8
    mem[18]   = 16'h0FF0;  // add r31,r16
    mem[19]   = 16'h0C55;  // add r5,r5
    mem[20]   = 16'hFFFF;  // no-op
    mem[21]   = 16'hCFE8;  // jump to 4094
    mem[4094] = 16'h9000;  // no-op
    mem[4095] = 16'hC12C;  // wraps to 0, then +300
    mem[300]  = 16'hC0FF;  // +255 -> 556
    for (int i = 0; i < 32; i++) mrf[i] = 8'd0;
    mpc = 12'd0;
    rst = 1'b1; dbg_we = 1'b0; dbg_sel = 5'd0; dbg_wdata = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pm_rd == 1'b0, "R1", pm_rd, 0);
    chk(dbg_pc == 12'd0, "R1", dbg_pc, 0);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) begin
      dbg_sel = 5'(i);
      #0.05;
      chk(dbg_reg == 8'd0, "R1", dbg_reg, 0);
    end
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      dbg_sel = 5'(i);
      dbg_we = 1'b1;
      dbg_wdata = 8'($urandom);
      if (i == 31) dbg_wdata = 8'hF0;
      if (i == 16) dbg_wdata = 8'h25;
      mrf[i] = dbg_wdata;
    end
    @(negedge clk);
    dbg_we = 1'b0;
    dbg_sel = 5'd31;
    #0.05;
    chk(dbg_reg == 8'hF0, "R8", dbg_reg, 8'hF0);
    wr_done = 1;
    wait (done);
    summary();
    $finish;
  end

  initial begin
    #(5.0 * 60000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", fetches, 3000);
      summary();
      $finish;
    end
  end
endmodule